// File: doc/BRIEF.md
# Replayable Ring FIFO with Half-Full Status

This block is a single-clock first-in/first-out buffer whose words are 9 bits wide, enough for a byte plus a parity or control bit. Data enter through a write enable and leave through a read enable. Neither side supplies an address, because the block keeps its own write and read positions in a ring-addressed memory whose depth is a parameter. Three registered status outputs report empty, full and more-than-half-full.

A rewind input returns the read position to the first memory location and leaves the write position where it is. Everything written since reset can then be read out again, for example to resend a frame after a transmission error. Requests that would overflow or underflow the buffer are dropped. Every accepted read produces a one-cycle valid strobe beside the read data.

Top module: `fifo_rt_buffer`

## Requirements
- R1: Words of 9 bits leave `rd_data` in the order they were accepted on `wr_data`, with all 9 bits preserved.
- R2: While `rst` is high, and in the first cycle after it falls, `empty` is 1, `full` is 0, `half_full` is 0 and `rd_valid` is 0. Both positions restart at location zero.
- R3: A write request made while `full` is 1 changes neither the memory nor the write position. The words read later are exactly the words stored before the request.
- R4: A read request made while `empty` is 1 gives no `rd_valid` pulse and does not move the read position. The next word written is the next word read.
- R5: `empty` is 1 exactly when occupancy is zero. With no reads after reset, `full` becomes 1 after exactly DEPTH accepted writes.
- R6: `half_full` is 1 exactly when occupancy is greater than DEPTH/2. It sets on the write that reaches DEPTH/2+1 and clears on the read that returns to DEPTH/2.
- R7: A cycle with `rewind` high sets the read position to location zero and keeps the write position. Occupancy becomes the number of writes since reset, provided that number is at most DEPTH. All three flags are re-evaluated from that occupancy. Read and write requests in that cycle are ignored.
- R8: A read and a write in the same cycle, with neither blocked, both take effect, and occupancy and flags stay unchanged.
- R9: Each accepted read yields `rd_valid`=1 for exactly one cycle, with its word on `rd_data`. Both, and all flag changes, appear at the clock edge that accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_data | input | 9 | Word to store |
| rd_en | input | 1 | Read request |
| rewind | input | 1 | Return read position to location zero |
| rd_data | output | 9 | Word read out, meaningful while rd_valid is 1 |
| rd_valid | output | 1 | One-cycle strobe per accepted read |
| empty | output | 1 | No words stored |
| full | output | 1 | DEPTH words stored |
| half_full | output | 1 | More than DEPTH/2 words stored |

## Verification
A request driven before clock edge k is accepted at edge k. The flags, `rd_valid` and `rd_data` all come from registers loaded at that same edge, so every result is due one edge after the request. The bench changes inputs on the falling edge and samples one nanosecond after the next rising edge, so each sample falls in the cycle where the result is due and ahead of any later request. Flag checks after rewind are made in the cycle right after the rewind edge, before any further request.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  localparam int WORD_W = 9;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_PUSH,
    OP_POP,
    OP_BOTH,
    OP_REWIND
  } fifo_op_e;
endpackage

// File: rtl/fifo_rt_mem.sv
module fifo_rt_mem #(
  parameter int W     = 9,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/fifo_rt_ctrl.sv
module fifo_rt_ctrl
  import fifo_rt_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          rewind,
  input  logic          is_empty,
  input  logic          is_full,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] level_nxt
);
  logic [CW-1:0] wpos_q;
  logic [AW-1:0] rpos_q;
  logic [CW-1:0] level_q;
  fifo_op_e      op;

  always_comb begin
    if (rewind) op = OP_REWIND;
    else begin
      unique case ({wr_en && !is_full, rd_en && !is_empty})
        2'b10:   op = OP_PUSH;
        2'b01:   op = OP_POP;
        2'b11:   op = OP_BOTH;
        default: op = OP_IDLE;
      endcase
    end
  end

  assign push_ok = (op == OP_PUSH) || (op == OP_BOTH);
  assign pop_ok  = (op == OP_POP)  || (op == OP_BOTH);
  assign waddr   = wpos_q[AW-1:0];
  assign raddr   = rpos_q;

  always_comb begin
    unique case (op)
      OP_PUSH:   level_nxt = level_q + 1'b1;
      OP_POP:    level_nxt = level_q - 1'b1;
      OP_REWIND: level_nxt = (wpos_q > CW'(DEPTH)) ? CW'(DEPTH) : wpos_q;
      default:   level_nxt = level_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wpos_q  <= '0;
      rpos_q  <= '0;
      level_q <= '0;
    end else begin
      level_q <= level_nxt;
      if (push_ok) wpos_q <= wpos_q + 1'b1;
      if (op == OP_REWIND) rpos_q <= '0;
      else if (pop_ok)     rpos_q <= rpos_q + 1'b1;
    end
  end
endmodule

// File: rtl/fifo_rt_flags.sv
module fifo_rt_flags #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1,
  localparam int HALF = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] level_nxt,
  output logic          empty,
  output logic          full,
  output logic          half_full
);
  always_ff @(posedge clk) begin
    if (rst) begin
      empty     <= 1'b1;
      full      <= 1'b0;
      half_full <= 1'b0;
    end else begin
      empty     <= (level_nxt == '0);
      full      <= (level_nxt == CW'(DEPTH));
      half_full <= (level_nxt > CW'(HALF));
    end
  end
endmodule

// File: rtl/fifo_rt_buffer.sv
module fifo_rt_buffer
  import fifo_rt_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rewind,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              empty,
  output logic              full,
  output logic              half_full
);
  logic          push_ok, pop_ok;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] level_nxt;

  fifo_rt_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .rewind(rewind),
    .is_empty(empty), .is_full(full), .push_ok(push_ok), .pop_ok(pop_ok),
    .waddr(waddr), .raddr(raddr), .level_nxt(level_nxt)
  );

  fifo_rt_mem #(.W(WORD_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(push_ok), .waddr(waddr), .wdata(wr_data),
    .re(pop_ok), .raddr(raddr), .rdata(rd_data)
  );

  fifo_rt_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst(rst), .level_nxt(level_nxt),
    .empty(empty), .full(full), .half_full(half_full)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= pop_ok;
  end
endmodule

// File: rtl/fifo_rt_chk.sv
module fifo_rt_chk (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic rd_en,
  input logic rewind,
  input logic rd_valid,
  input logic empty,
  input logic full,
  input logic half_full
);
  p_reset_state_r2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (empty && !full && !half_full && !rd_valid));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en && !rewind) |=> full);

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en) |=> !rd_valid);

  p_flag_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));

  p_fill_clears_empty_r5: assert property (@(posedge clk) disable iff (rst)
    (empty && wr_en && !rewind) |=> !empty);

  p_half_not_empty_r6: assert property (@(posedge clk) disable iff (rst)
    half_full |-> !empty);

  p_rewind_no_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    rewind |=> !rd_valid);

  p_valid_needs_read_r9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(rd_en) && !$past(empty)));
endmodule

bind fifo_rt_buffer fifo_rt_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .rewind(rewind),
  .rd_valid(rd_valid), .empty(empty), .full(full), .half_full(half_full)
);

// File: tb/fifo_rt_buffer_tb.sv
module fifo_rt_buffer_tb;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, rewind = 1'b0;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic       rd_valid, empty, full, half_full;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  fifo_rt_buffer #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rewind(rewind), .rd_data(rd_data), .rd_valid(rd_valid),
    .empty(empty), .full(full), .half_full(half_full)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [8:0] d, input logic r, input logic rw);
    @(negedge clk);
    wr_en = w; wr_data = d; rd_en = r; rewind = rw;
    @(posedge clk);
    #1;
    wr_en = 1'b0; rd_en = 1'b0; rewind = 1'b0;
  endtask

  function automatic logic [8:0] pat(input int i);
    return 9'((i * 37 + 5) ^ 9'h155);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R2 empty in reset", empty, 1);
    check("R2 full in reset", full, 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R2 empty after reset", empty, 1);
    check("R2 half_full after reset", half_full, 0);
    check("R2 rd_valid after reset", rd_valid, 0);
  endtask

  task automatic read_expect(input string req, input logic [8:0] exp);
    step(1'b0, '0, 1'b1, 1'b0);
    check({req, " rd_valid"}, rd_valid, 1);
    check({req, " rd_data"}, rd_data, exp);
  endtask

  task automatic t_fill_drain();
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b1, pat(i), 1'b0, 1'b0);
      if (i == 0) check("R5 empty clears on first write", empty, 0);
      if (i == DEPTH/2 - 1) check("R6 half_full at DEPTH/2", half_full, 0);
      if (i == DEPTH/2) check("R6 half_full at DEPTH/2+1", half_full, 1);
      if (i == DEPTH - 2) check("R5 full at DEPTH-1", full, 0);
    end
    check("R5 full after DEPTH writes", full, 1);
    step(1'b1, 9'h1FF, 1'b0, 1'b0);
    check("R3 full holds on blocked write", full, 1);
    check("R3 no strobe on blocked write", rd_valid, 0);
    for (int i = 0; i < DEPTH; i++) begin
      read_expect("R1 R3 drain order", pat(i));
      if (i == 0) check("R5 full clears on read", full, 0);
      if (i == DEPTH/2 - 2) check("R6 half_full at DEPTH/2+1", half_full, 1);
      if (i == DEPTH/2 - 1) check("R6 half_full clears at DEPTH/2", half_full, 0);
    end
    check("R5 empty after drain", empty, 1);
    step(1'b0, '0, 1'b0, 1'b0);
    check("R9 strobe lasts one cycle", rd_valid, 0);
  endtask

  task automatic t_underflow();
    do_reset();
    step(1'b0, '0, 1'b1, 1'b0);
    check("R4 no strobe when empty", rd_valid, 0);
    check("R4 still empty", empty, 1);
    step(1'b1, 9'h0A5, 1'b0, 1'b0);
    read_expect("R4 next write read next", 9'h0A5);
    check("R4 empty again", empty, 1);
  endtask

  task automatic t_simultaneous();
    do_reset();
    for (int i = 0; i < 3; i++) step(1'b1, pat(i), 1'b0, 1'b0);
    for (int i = 3; i < 8; i++) begin
      step(1'b1, pat(i), 1'b1, 1'b0);
      check("R8 strobe on joint op", rd_valid, 1);
      check("R8 data on joint op", rd_data, pat(i - 3));
      check("R8 not empty", empty, 0);
    end
    for (int i = 5; i < 8; i++) read_expect("R8 remainder", pat(i));
    check("R8 empty at end", empty, 1);
  endtask

  task automatic t_rewind();
    do_reset();
    for (int i = 0; i < 5; i++) step(1'b1, pat(i + 40), 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) read_expect("R7 pre-rewind", pat(i + 40));
    step(1'b1, 9'h111, 1'b1, 1'b1);
    check("R7 no strobe on rewind", rd_valid, 0);
    check("R7 empty after rewind", empty, 0);
    for (int i = 0; i < 5; i++) read_expect("R7 replay", pat(i + 40));
    check("R7 write ignored during rewind", empty, 1);
    step(1'b1, 9'h0C3, 1'b0, 1'b0);
    read_expect("R7 write position kept", 9'h0C3);

    do_reset();
    for (int i = 0; i < 10; i++) step(1'b1, pat(i), 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) step(1'b0, '0, 1'b1, 1'b0);
    check("R7 empty before rewind", empty, 1);
    step(1'b0, '0, 1'b0, 1'b1);
    check("R7 half_full re-evaluated", half_full, 1);
    check("R7 empty re-evaluated", empty, 0);

    do_reset();
    for (int i = 0; i < DEPTH; i++) step(1'b1, pat(i + 7), 1'b0, 1'b0);
    read_expect("R7 first read", pat(7));
    check("R7 full drops", full, 0);
    step(1'b0, '0, 1'b0, 1'b1);
    check("R7 full re-evaluated", full, 1);
    read_expect("R7 replay from zero", pat(7));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_fill_drain();
    t_underflow();
    t_simultaneous();
    t_rewind();
    summary();
  end
endmodule